// File: doc/BRIEF.md
# Stream Address and Count Sequencer

This block keeps the bookkeeping for one channel of a direct memory access engine. It holds the number of items still to move and the next address on each side: the fixed-function device side and the memory side. Whatever moves the data reports each completed item or burst through a strobe and an item count. The sequencer then lowers the remaining count by that amount and advances each address that has incrementing enabled. The step size on each side follows that side's data width.

When the count reaches zero the block follows one of three policies. A one-shot run switches the channel off. A ring run reloads the start count and returns both addresses to their bases. A ping-pong run also rings, but it moves the memory side to the other of two buffers, so software can work on one buffer while the channel fills the other. Every zero crossing gives a one-cycle completion pulse.

A start request first checks the configuration. If the configuration is unusable, the channel stays off and an error flag is raised.

Top module: `xfer_seq`

## Requirements
- R1: A start request while idle with a valid configuration sets `active`. It loads `remain` with `cfgCount`, `perAddr` with `cfgPerAddr` and `memAddr` with `cfgMemBase0`, clears `curTarget` and clears `cfgErr`. All of these are visible after the next clock edge.
- R2: A start request while idle does not set `active`, and sets `cfgErr`, in any of these cases: the start count is zero; a width code is 3; `cfgPerAddr` is misaligned for the device width; either memory base is misaligned for the memory width; or memory-to-memory is selected together with ring or ping-pong mode. Width codes are 0 for byte, 1 for half-word and 2 for word. Aligned means the low `code` address bits are zero.
- R3: A strobe with a nonzero amount lowers `remain` by that amount, limited to what remains. An amount of 0 changes nothing.
- R4: On a strobe that does not reach zero, each side with incrementing enabled advances by `amount << widthCode`. A side with incrementing disabled keeps its address.
- R5: In one-shot mode, reaching zero clears `active`, leaves `remain` at 0 with both addresses advanced, and raises `tcPulse` for exactly one cycle.
- R6: In ring mode, reaching zero keeps `active` set, reloads the start count, returns `perAddr` and `memAddr` to their bases and raises `tcPulse` for one cycle.
- R7: Ping-pong mode always rings. On each zero crossing `curTarget` toggles, and `memAddr` becomes the base of the newly selected buffer (buffer 0 when `curTarget`=0, buffer 1 when it is 1).
- R8: An abort while active clears `active` after the next edge with no `tcPulse`, even if a strobe arrives in the same cycle.
- R9: Strobes while idle are ignored. A start request while active is ignored and leaves `remain` and the addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to begin a run with the current configuration |
| abortReq | input | 1 | Stop the running channel |
| itemDone | input | 1 | One transfer (single item or burst) completed |
| itemAmt | input | AMT_W | Items moved by that transfer |
| cfgCount | input | CNT_W | Items per run |
| cfgPerAddr | input | ADDR_W | Device-side address |
| cfgMemBase0 | input | ADDR_W | Memory buffer 0 base |
| cfgMemBase1 | input | ADDR_W | Memory buffer 1 base |
| cfgPerWidth | input | 2 | Device width code |
| cfgMemWidth | input | 2 | Memory width code |
| cfgPerInc | input | 1 | Increment device address |
| cfgMemInc | input | 1 | Increment memory address |
| cfgCircular | input | 1 | Ring mode |
| cfgDoubleBuf | input | 1 | Ping-pong mode |
| cfgMemToMem | input | 1 | Memory-to-memory transfer |
| perAddr | output | ADDR_W | Current device address |
| memAddr | output | ADDR_W | Current memory address |
| remain | output | CNT_W | Items still to move |
| active | output | 1 | Channel running |
| curTarget | output | 1 | Memory buffer in use |
| tcPulse | output | 1 | One-cycle completion pulse |
| cfgErr | output | 1 | Last start was refused |

## Verification
A wrong count shows up on `remain` one edge after the strobe that caused it. If the error hides a zero crossing, `tcPulse`, `active` or `curTarget` fails to move at the edge where it should. A corrupted latched base or width does not show when it is latched. It shows on `memAddr` or `perAddr` at the next advance or wrap, which is why every sweep runs through at least one wrap. A wrong mode bit shows as `active` dropping, or failing to drop, in the cycle of the crossing.

// File: rtl/xfer_seq_pkg.sv
`timescale 1ns/1ps
package xfer_seq_pkg;
  typedef struct packed {
    logic load;   // latch configuration and begin a run
    logic step;   // subtract amount and advance addresses
    logic wrap;   // count hit zero in a ring run: reload
    logic swap;   // wrap that also changes buffer
  } seqStrobe_t;

  function automatic logic isAligned(input logic [1:0] low, input logic [1:0] code);
    case (code)
      2'd0: isAligned = 1'b1;
      2'd1: isAligned = (low[0] == 1'b0);
      2'd2: isAligned = (low == 2'b00);
      default: isAligned = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xfer_seq_ctrl.sv
`timescale 1ns/1ps
module xfer_seq_ctrl
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AMT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic             itemDone,
  input  logic [AMT_W-1:0] itemAmt,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [1:0]       perLow,
  input  logic [1:0]       memLow0,
  input  logic [1:0]       memLow1,
  input  logic [1:0]       cfgPerWidth,
  input  logic [1:0]       cfgMemWidth,
  input  logic             cfgCircular,
  input  logic             cfgDoubleBuf,
  input  logic             cfgMemToMem,
  input  logic [CNT_W-1:0] remain,
  output seqStrobe_t       strobe,
  output logic [CNT_W-1:0] stepAmt,
  output logic             active,
  output logic             cfgErr,
  output logic             tcPulse,
  output logic             circMode,
  output logic             dbMode
);
  logic [CNT_W-1:0] amtExt;
  logic cfgBad, doStart, doStep, hitZero;

  always_comb begin
    cfgBad = (cfgCount == '0)
           || (cfgPerWidth == 2'd3) || (cfgMemWidth == 2'd3)
           || !isAligned(perLow, cfgPerWidth)
           || !isAligned(memLow0, cfgMemWidth)
           || !isAligned(memLow1, cfgMemWidth)
           || (cfgMemToMem && (cfgCircular || cfgDoubleBuf));
    amtExt  = CNT_W'(itemAmt);
    stepAmt = (amtExt > remain) ? remain : amtExt;
    doStart = startReq && !active && !cfgBad;
    doStep  = active && !abortReq && itemDone && (itemAmt != '0);
    hitZero = doStep && (stepAmt == remain);
    strobe.load = doStart;
    strobe.step = doStep;
    strobe.wrap = hitZero && circMode;
    strobe.swap = hitZero && dbMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      cfgErr   <= 1'b0;
      tcPulse  <= 1'b0;
      circMode <= 1'b0;
      dbMode   <= 1'b0;
    end else begin
      tcPulse <= hitZero;
      if (startReq && !active) cfgErr <= cfgBad;
      if (doStart) begin
        active   <= 1'b1;
        circMode <= cfgCircular || cfgDoubleBuf;
        dbMode   <= cfgDoubleBuf;
      end else if (active && abortReq) begin
        active <= 1'b0;
      end else if (hitZero && !circMode) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_seq_dpath.sv
`timescale 1ns/1ps
module xfer_seq_dpath
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CNT_W-1:0]  stepAmt,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgPerAddr,
  input  logic [ADDR_W-1:0] cfgMemBase0,
  input  logic [ADDR_W-1:0] cfgMemBase1,
  input  logic [1:0]        cfgPerWidth,
  input  logic [1:0]        cfgMemWidth,
  input  logic              cfgPerInc,
  input  logic              cfgMemInc,
  output logic [ADDR_W-1:0] perAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CNT_W-1:0]  remain,
  output logic              curTarget
);
  logic [ADDR_W-1:0] perBase, memBase0, memBase1;
  logic [CNT_W-1:0]  reloadCnt;
  logic [1:0]        perW, memW;
  logic              perInc, memInc;
  logic [ADDR_W-1:0] amtAddr, perNext, memNext;

  always_comb begin
    amtAddr = ADDR_W'(stepAmt);
    perNext = perInc ? perAddr + (amtAddr << perW) : perAddr;
    memNext = memInc ? memAddr + (amtAddr << memW) : memAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perBase <= '0; memBase0 <= '0; memBase1 <= '0;
      reloadCnt <= '0; perW <= '0; memW <= '0;
      perInc <= 1'b0; memInc <= 1'b0;
      perAddr <= '0; memAddr <= '0; remain <= '0; curTarget <= 1'b0;
    end else if (strobe.load) begin
      perBase   <= cfgPerAddr;
      memBase0  <= cfgMemBase0;
      memBase1  <= cfgMemBase1;
      reloadCnt <= cfgCount;
      perW      <= cfgPerWidth;
      memW      <= cfgMemWidth;
      perInc    <= cfgPerInc;
      memInc    <= cfgMemInc;
      perAddr   <= cfgPerAddr;
      memAddr   <= cfgMemBase0;
      remain    <= cfgCount;
      curTarget <= 1'b0;
    end else if (strobe.wrap) begin
      remain  <= reloadCnt;
      perAddr <= perBase;
      if (strobe.swap) begin
        curTarget <= ~curTarget;
        memAddr   <= curTarget ? memBase0 : memBase1;
      end else begin
        memAddr <= curTarget ? memBase1 : memBase0;
      end
    end else if (strobe.step) begin
      remain  <= remain - stepAmt;
      perAddr <= perNext;
      memAddr <= memNext;
    end
  end
endmodule

// File: rtl/xfer_seq.sv
`timescale 1ns/1ps
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int AMT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              abortReq,
  input  logic              itemDone,
  input  logic [AMT_W-1:0]  itemAmt,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgPerAddr,
  input  logic [ADDR_W-1:0] cfgMemBase0,
  input  logic [ADDR_W-1:0] cfgMemBase1,
  input  logic [1:0]        cfgPerWidth,
  input  logic [1:0]        cfgMemWidth,
  input  logic              cfgPerInc,
  input  logic              cfgMemInc,
  input  logic              cfgCircular,
  input  logic              cfgDoubleBuf,
  input  logic              cfgMemToMem,
  output logic [ADDR_W-1:0] perAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CNT_W-1:0]  remain,
  output logic              active,
  output logic              curTarget,
  output logic              tcPulse,
  output logic              cfgErr
);
  seqStrobe_t       strobe;
  logic [CNT_W-1:0] stepAmt;
  logic             circMode, dbMode;

  xfer_seq_ctrl #(.CNT_W(CNT_W), .AMT_W(AMT_W)) i_ctrl (
    .clk, .rstN, .startReq, .abortReq, .itemDone, .itemAmt, .cfgCount,
    .perLow(cfgPerAddr[1:0]), .memLow0(cfgMemBase0[1:0]), .memLow1(cfgMemBase1[1:0]),
    .cfgPerWidth, .cfgMemWidth, .cfgCircular, .cfgDoubleBuf, .cfgMemToMem,
    .remain, .strobe, .stepAmt, .active, .cfgErr, .tcPulse, .circMode, .dbMode
  );

  xfer_seq_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dpath (
    .clk, .rstN, .strobe, .stepAmt, .cfgCount, .cfgPerAddr, .cfgMemBase0,
    .cfgMemBase1, .cfgPerWidth, .cfgMemWidth, .cfgPerInc, .cfgMemInc,
    .perAddr, .memAddr, .remain, .curTarget
  );
endmodule

// File: rtl/xfer_seq_chk.sv
`timescale 1ns/1ps
module xfer_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             abortReq,
  input logic             itemDone,
  input logic             active,
  input logic             cfgErr,
  input logic             tcPulse,
  input logic             curTarget,
  input logic             circMode,
  input logic             dbMode,
  input logic [CNT_W-1:0] remain
);
  // R2
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !active);
  // R1
  live_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> remain != '0);
  // R3
  remain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && $past(active) && !$past(itemDone) |-> $stable(remain));
  // R5
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> tcPulse || $past(abortReq));
  // R6
  ring_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse && circMode |-> active);
  // R7
  buffer_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse && dbMode |-> curTarget != $past(curTarget));
  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(abortReq) && $past(active) |-> !active && !tcPulse);
endmodule

bind xfer_seq xfer_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk, .rstN, .abortReq, .itemDone, .active, .cfgErr, .tcPulse,
  .curTarget, .circMode, .dbMode, .remain
);

// File: tb/test_xfer_seq.sv
`timescale 1ns/1ps
module test_xfer_seq;
  logic clk = 0, rstN = 0;
  logic startReq = 0, abortReq = 0, itemDone = 0;
  logic [4:0] itemAmt = 0;
  logic [15:0] cfgCount = 0;
  logic [31:0] cfgPerAddr = 0, cfgMemBase0 = 0, cfgMemBase1 = 0;
  logic [1:0] cfgPerWidth = 0, cfgMemWidth = 0;
  logic cfgPerInc = 0, cfgMemInc = 0, cfgCircular = 0, cfgDoubleBuf = 0, cfgMemToMem = 0;
  logic [31:0] perAddr, memAddr;
  logic [15:0] remain;
  logic active, curTarget, tcPulse, cfgErr;
  int runCnt = 0, failCnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_seq i_xfer_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1; tick(); startReq = 0;
  endtask

  task automatic pulseItem(input int amt);
    @(negedge clk); itemDone = 1; itemAmt = 5'(amt); tick(); itemDone = 0;
  endtask

  task automatic pulseAbort();
    @(negedge clk); abortReq = 1; tick(); abortReq = 0;
  endtask

  task automatic setGood(input int cnt);
    cfgCount = 16'(cnt); cfgPerAddr = 32'h4000_0000;
    cfgMemBase0 = 32'h1000; cfgMemBase1 = 32'h2000;
    cfgPerWidth = 2; cfgMemWidth = 2; cfgCircular = 0; cfgDoubleBuf = 0; cfgMemToMem = 0;
  endtask

  task automatic expectRefused(input string what);
    pulseStart();
    chk({"R2 active ", what}, active, 0);
    chk({"R2 err ", what}, cfgErr, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++; runCnt++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset active", active, 0);
    chk("R1 reset remain", remain, 0);
    chk("R1 reset tc", tcPulse, 0);
    @(negedge clk); rstN = 1;

    // Sweep: mode x widths x increments x count
    for (int mode = 0; mode < 3; mode++)
    for (int mw = 0; mw < 3; mw++)
    for (int pw = 0; pw < 3; pw++)
    for (int inc = 0; inc < 4; inc++)
    for (int ci = 0; ci < 2; ci++) begin
      int unsigned cnt = (ci == 0) ? 1 : 3;
      int unsigned eRem, eMem, ePer;
      bit eAct, eTc, eTgt;
      string mTag;
      mTag = (mode == 0) ? "R5" : (mode == 1) ? "R6" : "R7";
      setGood(cnt);
      cfgMemWidth = 2'(mw); cfgPerWidth = 2'(pw);
      cfgPerInc = inc[0]; cfgMemInc = inc[1];
      cfgCircular = (mode == 1); cfgDoubleBuf = (mode == 2);
      pulseStart();
      eRem = cnt; eMem = 32'h1000; ePer = 32'h4000_0000; eAct = 1; eTgt = 0;
      chk("R1 active", active, 1);
      chk("R1 remain", remain, eRem);
      chk("R1 memAddr", memAddr, eMem);
      chk("R1 perAddr", perAddr, ePer);
      chk("R1 target", curTarget, 0);
      chk("R1 err", cfgErr, 0);
      for (int s = 0; s < 7; s++) begin
        int unsigned a, n;
        a = (s % 3 == 2) ? 4 : (s % 3) + 1;
        eTc = 0;
        if (eAct) begin
          n = (a > eRem) ? eRem : a;
          eRem -= n;
          if (eRem == 0) begin
            eTc = 1;
            if (mode == 0) begin
              eAct = 0;
              if (inc[0]) ePer += n << pw;
              if (inc[1]) eMem += n << mw;
            end else begin
              eRem = cnt; ePer = 32'h4000_0000;
              if (mode == 2) eTgt = ~eTgt;
              eMem = eTgt ? 32'h2000 : 32'h1000;
            end
          end else begin
            if (inc[0]) ePer += n << pw;
            if (inc[1]) eMem += n << mw;
          end
        end
        pulseItem(a);
        chk("R3 remain", remain, eRem);
        chk("R4 memAddr", memAddr, eMem);
        chk("R4 perAddr", perAddr, ePer);
        chk({mTag, " active"}, active, eAct);
        chk({mTag, " tc"}, tcPulse, eTc);
        chk({mTag, " target"}, curTarget, eTgt);
        if (eTc) begin
          tick();
          chk({mTag, " tc one cycle"}, tcPulse, 0);
        end
      end
      if (mode == 0) chk("R9 idle strobes ignored", remain, 0);
      if (eAct) begin
        @(negedge clk); abortReq = 1; itemDone = 1; itemAmt = 5'(cnt);
        tick(); abortReq = 0; itemDone = 0;
        chk("R8 abort active", active, 0);
        chk("R8 abort tc", tcPulse, 0);
        chk("R8 abort remain", remain, eRem);
      end
    end

    // Zero amount and start while active
    setGood(5); cfgMemInc = 1; cfgPerInc = 1;
    pulseStart();
    pulseItem(0);
    chk("R3 zero amount remain", remain, 5);
    chk("R3 zero amount memAddr", memAddr, 32'h1000);
    pulseItem(2);
    cfgCount = 9; cfgMemBase0 = 32'h3000;
    pulseStart();
    chk("R9 restart remain", remain, 3);
    chk("R9 restart memAddr", memAddr, 32'h1008);
    pulseAbort();

    // Refused configurations
    setGood(0);               expectRefused("zero count");
    setGood(4); cfgPerWidth = 3; expectRefused("width code 3");
    setGood(4); cfgMemWidth = 1; cfgMemBase0 = 32'h1001; expectRefused("base0 misaligned");
    setGood(4); cfgMemBase1 = 32'h2002; expectRefused("base1 misaligned");
    setGood(4); cfgPerAddr = 32'h4000_0002; expectRefused("device misaligned");
    setGood(4); cfgMemToMem = 1; cfgCircular = 1; expectRefused("m2m ring");
    setGood(4); cfgMemToMem = 1; cfgDoubleBuf = 1; expectRefused("m2m ping-pong");
    setGood(4); cfgMemToMem = 1; cfgMemWidth = 1; cfgMemBase0 = 32'h1002; cfgMemBase1 = 32'h2006;
    pulseStart();
    chk("R1 m2m one-shot active", active, 1);
    chk("R1 error cleared", cfgErr, 0);
    chk("R1 m2m remain", remain, 4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule